// File: doc/BRIEF.md
# Stepped-Frequency Sine and Ramp Sample Source

This block is a numerically controlled signal source. Each clock a 32-bit phase register adds a tuning word to itself. The top 8 bits of that phase either index a 256-entry sine table or go straight out as a ramp. The result leaves as an 8-bit sample every clock, with a valid strobe. The ramp runs at one fixed rate. In sine mode the rate is a decimal setting in kilohertz that runs from 1 to 10. Two single-cycle pulse inputs step it up or down by 1 kHz. The setting is also shown as two BCD digits and two active-low seven-segment patterns, for a two-digit display. A converter and reconstruction filter would follow the sample port. They are not part of this block.

The setting is held by a three-state machine. ST_FLOOR means the setting is at 1 kHz, ST_CEIL means it is at 10 kHz, and ST_INNER covers everything between. A lone up pulse is a rise: ST_FLOOR or ST_INNER goes to ST_INNER, or to ST_CEIL when the new value is the top. A lone down pulse is a fall: ST_CEIL or ST_INNER goes to ST_INNER, or to ST_FLOOR when the new value is the bottom. The state holds in four cases: an up pulse in ST_CEIL, a down pulse in ST_FLOOR, both pulses together, and neither pulse. The phase is never cleared by a change of setting.

Top module: `dds_wavegen`

## Requirements
- R1: `rst` is a synchronous reset and takes priority over every other input. At each clock edge where it is high, the phase becomes 0, the setting becomes 1 kHz and `sample_vld` becomes 0. Step pulses during reset are ignored. The first sample after reset is therefore taken from phase 0.
- R2: A step-up pulse alone raises the setting by 1 kHz at that clock edge. At 10 kHz it is ignored.
- R3: A step-down pulse alone lowers the setting by 1 kHz at that clock edge. At 1 kHz it is ignored.
- R4: Step-up and step-down high in the same cycle leave the setting unchanged.
- R5: Each clock the phase grows by a tuning word, modulo 2^32. For a setting of f kHz the word is floor((f·1000·2^32 + 25,000,000) / 50,000,000), which is f·1000·2^32 / 50 MHz rounded to the nearest integer.
- R6: When `mode_sine` is 1 at a clock edge, `sample` takes 128 + round(127·sin(2πk/256)), rounded half away from zero. Here k is bits 31:24 of the phase before that edge.
- R7: When `mode_sine` is 0 at a clock edge, `sample` takes bits 31:24 of the phase before that edge, and the phase grows by the 1 kHz word whatever the setting. The setting can still be stepped while in this mode.
- R8: A change of setting or mode does not reset the phase. The new word is first added at the clock edge after the setting changed, or at the edge where the new mode is applied.
- R9: `bcd_tens` and `bcd_ones` give the setting in decimal, from 0,1 up to 1,0. They follow the setting in the same cycle.
- R10: Each segment output is active low, with bit 0 = segment a through bit 6 = segment g. Digits 0 to 9 map to 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000, 0010000.
- R11: `sample_vld` is 1 after every clock edge at which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 50 MHz |
| rst | input | 1 | Synchronous reset, active high |
| mode_sine | input | 1 | 1 selects sine output, 0 selects ramp |
| step_up | input | 1 | One-cycle pulse, raise setting by 1 kHz |
| step_dn | input | 1 | One-cycle pulse, lower setting by 1 kHz |
| sample | output | 8 | Output sample, offset binary |
| sample_vld | output | 1 | Sample strobe |
| bcd_tens | output | 4 | Tens digit of the setting in kHz |
| bcd_ones | output | 4 | Units digit of the setting in kHz |
| seg_tens | output | 7 | Active-low segments for the tens digit |
| seg_ones | output | 7 | Active-low segments for the units digit |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the two step pulses: the bench raises both together at the floor, in the middle and at the ceiling, and expects the setting to hold. The second pair is a setting change and a mode switch: the bench steps the setting in the same cycle that `mode_sine` flips, and also in the cycles around it. A reference phase model in the bench judges every sample. Any early or late use of the new tuning word, or any reset of the phase, shows up as a mismatched sample.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        ST_FLOOR = 2'd0,
        ST_INNER = 2'd1,
        ST_CEIL  = 2'd2
    } fsel_state_e;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_UP   = 2'd1,
        MV_DOWN = 2'd2
    } fsel_move_e;

    // rounded phase increment for a frequency given in kHz
    function automatic logic [63:0] tune_word(input int unsigned khz,
                                              input int unsigned clk_hz,
                                              input int unsigned acc_w);
        logic [63:0] num;
        logic [63:0] den;
        num = (64'(khz) * 64'd1000) << acc_w;
        den = 64'(clk_hz);
        return (num + (den >> 1)) / den;
    endfunction

    // offset-binary sine code for table entry k
    function automatic int sine_code(input int k, input int aw, input int ow);
        real amp;
        real ang;
        real v;
        int  r;
        amp = real'((1 << (ow - 1)) - 1);
        ang = 2.0 * 3.14159265358979323846 * real'(k) / real'(1 << aw);
        v   = amp * $sin(ang);
        if (v >= 0.0) r = $rtoi(v + 0.5);
        else          r = -$rtoi(0.5 - v);
        return (1 << (ow - 1)) + r;
    endfunction

endpackage

// File: rtl/dds_freq_sel.sv
module dds_freq_sel
    import dds_pkg::*;
#(
    parameter int F_MIN = 1,
    parameter int F_MAX = 10,
    parameter int KHZ_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [KHZ_W-1:0] khz
);
    localparam logic [KHZ_W-1:0] K_MIN = KHZ_W'(F_MIN);
    localparam logic [KHZ_W-1:0] K_MAX = KHZ_W'(F_MAX);

    fsel_state_e      state_q, state_d;
    logic [KHZ_W-1:0] khz_q, khz_d;
    fsel_move_e       move;

    always_comb begin
        if (step_up && !step_dn)      move = MV_UP;
        else if (step_dn && !step_up) move = MV_DOWN;
        else                          move = MV_HOLD;
    end

    // next state and next setting
    always_comb begin
        state_d = state_q;
        khz_d   = khz_q;
        unique case (state_q)
            ST_FLOOR: begin
                if (move == MV_UP) begin
                    khz_d   = khz_q + 1'b1;
                    state_d = (khz_q + 1'b1 == K_MAX) ? ST_CEIL : ST_INNER;
                end
            end
            ST_INNER: begin
                if (move == MV_UP) begin
                    khz_d   = khz_q + 1'b1;
                    state_d = (khz_q + 1'b1 == K_MAX) ? ST_CEIL : ST_INNER;
                end else if (move == MV_DOWN) begin
                    khz_d   = khz_q - 1'b1;
                    state_d = (khz_q - 1'b1 == K_MIN) ? ST_FLOOR : ST_INNER;
                end
            end
            ST_CEIL: begin
                if (move == MV_DOWN) begin
                    khz_d   = khz_q - 1'b1;
                    state_d = (khz_q - 1'b1 == K_MIN) ? ST_FLOOR : ST_INNER;
                end
            end
            default: begin
                state_d = ST_FLOOR;
                khz_d   = K_MIN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FLOOR;
            khz_q   <= K_MIN;
        end else begin
            state_q <= state_d;
            khz_q   <= khz_d;
        end
    end

    // outputs
    always_comb begin
        khz = khz_q;
    end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 32,
    parameter int TOP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] tw,
    output logic [TOP_W-1:0] phase_top
);
    logic [ACC_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + tw;
    end

    assign phase_top = phase_q[ACC_W-1 -: TOP_W];
endmodule

// File: rtl/dds_wave_rom.sv
module dds_wave_rom
    import dds_pkg::*;
#(
    parameter int AW = 8,
    parameter int OW = 8
) (
    input  logic [AW-1:0] idx,
    output logic [OW-1:0] code
);
    localparam int DEPTH = 1 << AW;

    logic [OW-1:0] tab [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        assign tab[k] = OW'(sine_code(k, AW, OW));
    end

    assign code = tab[idx];
endmodule

// File: rtl/dds_digit_dec.sv
module dds_digit_dec (
    input  logic [3:0] bcd,
    output logic [6:0] seg
);
    // active low, bit0 = a ... bit6 = g
    always_comb begin
        unique case (bcd)
            4'd0:    seg = 7'b1000000;
            4'd1:    seg = 7'b1111001;
            4'd2:    seg = 7'b0100100;
            4'd3:    seg = 7'b0110000;
            4'd4:    seg = 7'b0011001;
            4'd5:    seg = 7'b0010010;
            4'd6:    seg = 7'b0000010;
            4'd7:    seg = 7'b1111000;
            4'd8:    seg = 7'b0000000;
            4'd9:    seg = 7'b0010000;
            default: seg = 7'b1111111;
        endcase
    end
endmodule

// File: rtl/dds_wavegen.sv
module dds_wavegen
    import dds_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int ACC_W     = 32,
    parameter int OUT_W     = 8,
    parameter int F_MIN_KHZ = 1,
    parameter int F_MAX_KHZ = 10,
    parameter int SAW_KHZ   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_sine,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [OUT_W-1:0] sample,
    output logic             sample_vld,
    output logic [3:0]       bcd_tens,
    output logic [3:0]       bcd_ones,
    output logic [6:0]       seg_tens,
    output logic [6:0]       seg_ones
);
    localparam int KHZ_W = $clog2(F_MAX_KHZ + 1);
    localparam logic [ACC_W-1:0] TW_SAW = ACC_W'(tune_word(SAW_KHZ, CLK_HZ, ACC_W));

    logic [KHZ_W-1:0] khz;
    logic [ACC_W-1:0] tw_tab [F_MIN_KHZ:F_MAX_KHZ];
    logic [ACC_W-1:0] tw_sel;
    logic [OUT_W-1:0] phase_top;
    logic [OUT_W-1:0] sine_val;
    logic [7:0]       khz8;
    logic [3:0]       digit [2];
    logic [6:0]       seg   [2];

    dds_freq_sel #(.F_MIN(F_MIN_KHZ), .F_MAX(F_MAX_KHZ), .KHZ_W(KHZ_W)) u_fsel (
        .clk(clk), .rst(rst), .step_up(step_up), .step_dn(step_dn), .khz(khz)
    );

    for (genvar g = F_MIN_KHZ; g <= F_MAX_KHZ; g++) begin : g_tw
        assign tw_tab[g] = ACC_W'(tune_word(g, CLK_HZ, ACC_W));
    end

    assign tw_sel = mode_sine ? tw_tab[khz] : TW_SAW;

    dds_phase_acc #(.ACC_W(ACC_W), .TOP_W(OUT_W)) u_acc (
        .clk(clk), .rst(rst), .tw(tw_sel), .phase_top(phase_top)
    );

    dds_wave_rom #(.AW(OUT_W), .OW(OUT_W)) u_rom (
        .idx(phase_top), .code(sine_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample     <= '0;
            sample_vld <= 1'b0;
        end else begin
            sample     <= mode_sine ? sine_val : phase_top;
            sample_vld <= 1'b1;
        end
    end

    assign khz8     = 8'(khz);
    assign digit[0] = 4'(khz8 % 8'd10);
    assign digit[1] = 4'(khz8 / 8'd10);

    for (genvar d = 0; d < 2; d++) begin : g_digit
        dds_digit_dec u_dec (.bcd(digit[d]), .seg(seg[d]));
    end

    assign bcd_ones = digit[0];
    assign bcd_tens = digit[1];
    assign seg_ones = seg[0];
    assign seg_tens = seg[1];
endmodule

// File: rtl/dds_wavegen_chk.sv
module dds_wavegen_chk #(
    parameter int OUT_W     = 8,
    parameter int F_MIN_KHZ = 1,
    parameter int F_MAX_KHZ = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_sine,
    input logic             step_up,
    input logic             step_dn,
    input logic [OUT_W-1:0] sample,
    input logic             sample_vld,
    input logic [3:0]       bcd_tens,
    input logic [3:0]       bcd_ones
);
    logic [7:0] khz_c;
    assign khz_c = 8'(bcd_tens) * 8'd10 + 8'(bcd_ones);

    AST_VLD_IN_RESET: assert property (@(posedge clk) rst |=> !sample_vld); // R1

    AST_VLD_RUNNING: assert property (@(posedge clk) !rst |=> sample_vld); // R11

    AST_RISE_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_up && !step_dn && khz_c < 8'(F_MAX_KHZ)) |=> khz_c == $past(khz_c) + 8'd1); // R2

    AST_RISE_SAT: assert property (@(posedge clk) disable iff (rst)
        (step_up && !step_dn && khz_c == 8'(F_MAX_KHZ)) |=> khz_c == 8'(F_MAX_KHZ)); // R2

    AST_FALL_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_dn && !step_up && khz_c > 8'(F_MIN_KHZ)) |=> khz_c == $past(khz_c) - 8'd1); // R3

    AST_FALL_SAT: assert property (@(posedge clk) disable iff (rst)
        (step_dn && !step_up && khz_c == 8'(F_MIN_KHZ)) |=> khz_c == 8'(F_MIN_KHZ)); // R3

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step_up && step_dn) |=> $stable(khz_c)); // R4

    AST_BCD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (bcd_ones <= 4'd9) && (khz_c >= 8'(F_MIN_KHZ)) && (khz_c <= 8'(F_MAX_KHZ))); // R9

    AST_RAMP_SMOOTH: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && $past(sample_vld) && !$past(mode_sine) && !$past(mode_sine, 2))
        |-> (sample == $past(sample) || sample == $past(sample) + 1'b1)); // R7
endmodule

bind dds_wavegen dds_wavegen_chk #(
    .OUT_W(OUT_W), .F_MIN_KHZ(F_MIN_KHZ), .F_MAX_KHZ(F_MAX_KHZ)
) u_chk (.*);

// File: tb/sim_dds_wavegen.sv
module sim_dds_wavegen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sine = 1'b1;
    logic       step_up = 1'b0;
    logic       step_dn = 1'b0;
    logic [7:0] sample;
    logic       sample_vld;
    logic [3:0] bcd_tens, bcd_ones;
    logic [6:0] seg_tens, seg_ones;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_phase;
    int          m_khz;
    bit          m_moved;

    dds_wavegen u0 (
        .clk(clk), .rst(rst), .mode_sine(mode_sine), .step_up(step_up), .step_dn(step_dn),
        .sample(sample), .sample_vld(sample_vld), .bcd_tens(bcd_tens), .bcd_ones(bcd_ones),
        .seg_tens(seg_tens), .seg_ones(seg_ones)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] ref_tw(input int khz);
        logic [63:0] num;
        num = (64'(khz) * 64'd1000) << 32;
        return 32'((num + 64'd25_000_000) / 64'd50_000_000);
    endfunction

    function automatic logic [7:0] ref_sine(input int k);
        real v;
        int  r;
        v = 127.0 * $sin(2.0 * 3.14159265358979323846 * real'(k) / 256.0);
        r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
        return 8'(128 + r);
    endfunction

    function automatic logic [6:0] ref_seg(input int d);
        case (d)
            0: return 7'b1000000;  1: return 7'b1111001;
            2: return 7'b0100100;  3: return 7'b0110000;
            4: return 7'b0011001;  5: return 7'b0010010;
            6: return 7'b0000010;  7: return 7'b1111000;
            8: return 7'b0000000;  default: return 7'b0010000;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_display(input string tag);
        check({tag, " tens R9"}, int'(bcd_tens), m_khz / 10);
        check({tag, " ones R9"}, int'(bcd_ones), m_khz % 10);
        check({tag, " seg_tens R10"}, int'(seg_tens), int'(ref_seg(m_khz / 10)));
        check({tag, " seg_ones R10"}, int'(seg_ones), int'(ref_seg(m_khz % 10)));
    endtask

    // one clock with given inputs, model advanced in step
    task automatic tick(input logic up, input logic dn, input logic md);
        logic [7:0] exp_s;
        bit         was_moved;
        @(negedge clk);
        rst = 1'b0; step_up = up; step_dn = dn; mode_sine = md;
        was_moved = m_moved;
        exp_s   = md ? ref_sine(int'(m_phase[31:24])) : m_phase[31:24];
        m_phase = m_phase + (md ? ref_tw(m_khz) : ref_tw(1));
        m_moved = 1'b0;
        if (up && !dn && m_khz < 10) begin m_khz++; m_moved = 1'b1; end
        else if (dn && !up && m_khz > 1) begin m_khz--; m_moved = 1'b1; end
        @(posedge clk); #1;
        if (was_moved)  check("R8 sample after setting change", int'(sample), int'(exp_s));
        else if (md)    check("R5/R6 sine sample", int'(sample), int'(exp_s));
        else            check("R7 ramp sample", int'(sample), int'(exp_s));
        check("R11 valid", int'(sample_vld), 1);
        check_display("R2/R3/R4 setting");
    endtask

    task automatic do_reset(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            rst = 1'b1; step_up = (i == 0); step_dn = 1'b0;
            @(posedge clk); #1;
            m_phase = '0; m_khz = 1; m_moved = 1'b0;
            check("R1 valid low in reset", int'(sample_vld), 0);
            check_display("R1 reset");
        end
    endtask

    initial begin
        void'($urandom(32'd20240607));
        m_phase = '0; m_khz = 1; m_moved = 1'b0;
        do_reset(3);

        // first sample from phase 0
        tick(1'b0, 1'b0, 1'b1);
        check("R1 first sine sample", int'(sample), 128);

        // down at floor, both at floor
        tick(1'b0, 1'b1, 1'b1);
        tick(1'b1, 1'b1, 1'b1);
        check("R3 floor hold", m_khz, 1);
        // walk to ceiling and beyond
        for (int i = 0; i < 12; i++) begin
            tick(1'b1, 1'b0, 1'b1);
            repeat (3) tick(1'b0, 1'b0, 1'b1);
        end
        check("R2 ceiling", int'(bcd_tens) * 10 + int'(bcd_ones), 10);
        tick(1'b1, 1'b1, 1'b1);
        // step at the same edge as a mode switch
        tick(1'b0, 1'b1, 1'b0);
        repeat (50) tick(1'b0, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b1);
        tick(1'b0, 1'b0, 1'b1);
        // ramp long enough to wrap at 1 kHz
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b1, 1'b1);
        repeat (600) tick(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0);
        repeat (51000) tick(1'b0, 1'b0, 1'b0);

        // reset mid-run, with a step pulse inside reset
        do_reset(2);
        tick(1'b0, 1'b0, 1'b0);
        check("R1 first ramp sample", int'(sample), 0);

        // random stretch
        begin
            logic md = 1'b1;
            for (int i = 0; i < 60000; i++) begin
                int r;
                logic up, dn;
                r  = int'($urandom_range(0, 999));
                up = (r < 6) || (r == 999);
                dn = (r >= 6 && r < 12) || (r == 999);
                if ($urandom_range(0, 1999) == 0) md = ~md;
                tick(up, dn, md);
            end
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule